// File: doc/BRIEF.md
# Banked Memory Chip-Select Controller

This block sits beside an 8-bit microcontroller with a 16-bit address bus and turns bus addresses into chip selects for external memory. At power-up the controller writes a small bank of sixteen 8-bit control registers through an I/O strobe. From those registers, the current address and the incoming strobes, the block drives active-low selects for an EEPROM, two flash devices and external SRAM. It also drives four extended address lines that place one 16 KB flash bank into a fixed window, and three active-low peripheral selects, each tied to a programmable page range.

The 16 KB bank window spans 0x4000–0x7FFF. The fixed 32 KB common region spans 0x8000–0xFFFF and always reads from the bottom of flash device 1. One register bit swaps the EEPROM into the bank window in place of flash. A bootstrap input overlays a fixed map in which internal resources own three address ranges. No external select fires in those ranges.

Top module: `bank_cs_ctrl`

## Requirements
- R1: After reset every register reads 0x00, no peripheral select is asserted and the EEPROM swap is off.
- R2: A register is addressed when `io_cs_n` is low and address bits 9, 8 and 4 are all 0; bits 3:0 give the index, so the set is mirrored across the page (0x1400 and 0x1440 reach the same register). A write (`rd_wr`=0) lands on the next rising clock edge. A read (`rd_wr`=1) returns the contents on `rdata`, which is 0x00 at all other times. An access with bit 4 set is ignored. Registers 8–15 are plain storage.
- R3: With `prog_cs_n` low and the address in 0x4000–0x7FFF, register 0 bits 3:0 give the bank. Bank bit 3 = 0 asserts `flash1_cs_n`, and bank bit 3 = 1 asserts `flash2_cs_n`. {`ext_a17`,`ext_a16`,`win_a15`,`win_a14`} equals the bank number.
- R4: With `prog_cs_n` low and the address in 0x8000–0xFFFF, `flash1_cs_n` is asserted and {`ext_a17`,`ext_a16`,`win_a15`} = 0 with `win_a14` = address bit 14. Outside the bank window the extended lines always take this form.
- R5: When register 1 bit 0 is 1, a window access asserts `ee_cs_n` and neither flash select, and the extended lines still carry the bank number. Common-region accesses are unaffected.
- R6: The flash and EEPROM selects assert only while `prog_cs_n` is low. `sram_cs_n` asserts only while `gen_cs_n` is low and the address is below 0x4000.
- R7: Peripheral k (k = 0..2) takes its start page from register 2+2k and its end page from register 3+2k, where a page is address bits 15:8. Its select is asserted exactly when the start page is nonzero and start ≤ page ≤ end.
- R8: While `boot_mode` is high, addresses in 0x0000–0x03FF, 0xB600–0xBFFF and 0xFE00–0xFFFF assert no memory select and no peripheral select. Other addresses decode as in normal mode.
- R9: At most one of `ee_cs_n`, `flash1_cs_n`, `flash2_cs_n` and `sram_cs_n` is asserted for any address and strobe combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Microcontroller address bus |
| rd_wr | input | 1 | 1 = read, 0 = write |
| io_cs_n | input | 1 | Active-low I/O strobe for the register page |
| prog_cs_n | input | 1 | Active-low program-space strobe qualifying flash/EEPROM |
| gen_cs_n | input | 1 | Active-low general strobe qualifying SRAM |
| boot_mode | input | 1 | Selects the bootstrap overlay map |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, 0x00 when not reading |
| ee_cs_n | output | 1 | EEPROM select, active low |
| flash1_cs_n | output | 1 | Flash device 1 select, active low |
| flash2_cs_n | output | 1 | Flash device 2 select, active low |
| sram_cs_n | output | 1 | External SRAM select, active low |
| win_a14 | output | 1 | Remapped address bit 14 |
| win_a15 | output | 1 | Remapped address bit 15 |
| ext_a16 | output | 1 | Extended address bit 16 |
| ext_a17 | output | 1 | Extended address bit 17 |
| periph_cs_n | output | 3 | Peripheral range selects, active low |

## Verification
The hardest situation to reach is a collision between selects. It needs both strobes asserted together, the EEPROM swap on, an upper-device bank selected and the bootstrap overlay active, all at the same time. No single directed address lands on it. The bench therefore programs several register configurations through the bus tasks. For each one it holds `prog_cs_n` and `gen_cs_n` low at once and sweeps all 65,536 addresses. At every address it counts the asserted memory selects and compares the full output set against its own model.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int ADDR_W = 16;
  localparam int PAGE_W = 8;
  localparam int BANK_W = 4;

  typedef struct packed {
    logic ee;
    logic f1;
    logic f2;
    logic sram;
  } mem_sel_t;

  // peripheral range test on address pages; a zero start page disables it
  function automatic logic page_hit(input logic [PAGE_W-1:0] page,
                                    input logic [PAGE_W-1:0] lo,
                                    input logic [PAGE_W-1:0] hi);
    return (lo != '0) && (page >= lo) && (page <= hi);
  endfunction

  // ranges owned by internal resources while bootstrapping
  function automatic logic boot_owned(input logic [ADDR_W-1:0] a);
    return (a <= 16'h03FF) ||
           ((a >= 16'hB600) && (a <= 16'hBFFF)) ||
           (a >= 16'hFE00);
  endfunction

  // extended address lines: bank inside the window, bottom of device 1 elsewhere
  function automatic logic [BANK_W-1:0] ext_lines(input logic [ADDR_W-1:0] a,
                                                  input logic [BANK_W-1:0] bank);
    if (a[15:14] == 2'b01) return bank;
    return {{(BANK_W-1){1'b0}}, a[14]};
  endfunction
endpackage

// File: rtl/bcc_regfile.sv
module bcc_regfile #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel,
  input  logic                       rd_wr,
  input  logic [IDX_W-1:0]           idx,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic wr_fire;
  logic rd_fire;

  assign wr_fire = sel && !rd_wr;
  assign rd_fire = sel && rd_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (wr_fire) begin
      regs_q[idx] <= wdata;
    end
  end

  assign rdata = rd_fire ? regs_q[idx] : '0;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = regs_q[g];
  end

  // R2: a write is visible in the addressed register one edge later
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> regs_q[$past(idx)] == $past(wdata));

  // R2: no access leaves every register unchanged
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(regs_flat));
endmodule

// File: rtl/bcc_mem_decode.sv
module bcc_mem_decode
  import bcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              prog_cs_n,
  input  logic              gen_cs_n,
  input  logic              boot_mode,
  input  logic [BANK_W-1:0] bank,
  input  logic              ee_swap,
  output mem_sel_t          sel,
  output logic [BANK_W-1:0] ext
);
  logic in_window;
  logic in_common;
  logic in_low;
  logic suppress;

  assign in_window = (addr[15:14] == 2'b01);
  assign in_common = addr[15];
  assign in_low    = (addr[15:14] == 2'b00);
  assign suppress  = boot_mode && boot_owned(addr);

  always_comb begin
    sel = '0;
    if (!suppress) begin
      if (!prog_cs_n && in_window) begin
        if (ee_swap)                sel.ee = 1'b1;
        else if (bank[BANK_W-1])    sel.f2 = 1'b1;
        else                        sel.f1 = 1'b1;
      end else if (!prog_cs_n && in_common) begin
        sel.f1 = 1'b1;
      end
      if (!gen_cs_n && in_low) sel.sram = 1'b1;
    end
  end

  assign ext = ext_lines(addr, bank);

  // R9: memory selects are mutually exclusive
  assert_one_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  // R6: flash and EEPROM need the program strobe, SRAM the general strobe
  assert_prog_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.ee || sel.f1 || sel.f2) |-> !prog_cs_n);
  assert_gen_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel.sram |-> (!gen_cs_n && addr < 16'h4000));

  // R4: common accesses read from the bottom of device 1
  assert_common_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.f1 && in_common) |-> (ext[BANK_W-1:1] == '0));

  // R5: swap never lets flash into the window
  assert_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_swap && in_window) |-> !(sel.f1 || sel.f2));
endmodule

// File: rtl/bcc_periph_decode.sv
module bcc_periph_decode
  import bcc_pkg::*;
#(
  parameter int NUM_PERIPH = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PAGE_W-1:0]            page,
  input  logic                         suppress,
  input  logic [NUM_PERIPH*PAGE_W-1:0] lo_flat,
  input  logic [NUM_PERIPH*PAGE_W-1:0] hi_flat,
  output logic [NUM_PERIPH-1:0]        cs_n
);
  for (genvar k = 0; k < NUM_PERIPH; k++) begin : g_per
    logic [PAGE_W-1:0] lo;
    logic [PAGE_W-1:0] hi;
    logic              hit;
    assign lo  = lo_flat[k*PAGE_W +: PAGE_W];
    assign hi  = hi_flat[k*PAGE_W +: PAGE_W];
    assign hit = page_hit(page, lo, hi) && !suppress;
    assign cs_n[k] = !hit;

    // R7: a select only fires inside an enabled range
    assert_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n[k] |-> (lo != '0 && page >= lo && page <= hi));
  end
endmodule

// File: rtl/bank_cs_ctrl.sv
module bank_cs_ctrl
  import bcc_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int DATA_W     = 8,
  parameter int NUM_PERIPH = 3,
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           addr,
  input  logic                  rd_wr,
  input  logic                  io_cs_n,
  input  logic                  prog_cs_n,
  input  logic                  gen_cs_n,
  input  logic                  boot_mode,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic                  ee_cs_n,
  output logic                  flash1_cs_n,
  output logic                  flash2_cs_n,
  output logic                  sram_cs_n,
  output logic                  win_a14,
  output logic                  win_a15,
  output logic                  ext_a16,
  output logic                  ext_a17,
  output logic [NUM_PERIPH-1:0] periph_cs_n
);
  localparam int BANK_REG = 0;
  localparam int CFG_REG  = 1;
  localparam int PER_BASE = 2;

  logic                         reg_sel;
  logic [NUM_REGS*DATA_W-1:0]   regs_flat;
  logic [BANK_W-1:0]            bank;
  logic                         ee_swap;
  logic                         boot_block;
  mem_sel_t                     msel;
  logic [BANK_W-1:0]            ext;
  logic [NUM_PERIPH*PAGE_W-1:0] lo_flat;
  logic [NUM_PERIPH*PAGE_W-1:0] hi_flat;

  // register page decode: strobe plus A9, A8, A4 clear
  assign reg_sel = !io_cs_n && !addr[9] && !addr[8] && !addr[4];

  bcc_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (reg_sel),
    .rd_wr     (rd_wr),
    .idx       (addr[IDX_W-1:0]),
    .wdata     (wdata),
    .rdata     (rdata),
    .regs_flat (regs_flat)
  );

  assign bank    = regs_flat[BANK_REG*DATA_W +: BANK_W];
  assign ee_swap = regs_flat[CFG_REG*DATA_W];

  for (genvar k = 0; k < NUM_PERIPH; k++) begin : g_rng
    assign lo_flat[k*PAGE_W +: PAGE_W] = regs_flat[(PER_BASE+2*k)*DATA_W +: PAGE_W];
    assign hi_flat[k*PAGE_W +: PAGE_W] = regs_flat[(PER_BASE+2*k+1)*DATA_W +: PAGE_W];
  end

  assign boot_block = boot_mode && boot_owned(addr);

  bcc_mem_decode u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .prog_cs_n (prog_cs_n),
    .gen_cs_n  (gen_cs_n),
    .boot_mode (boot_mode),
    .bank      (bank),
    .ee_swap   (ee_swap),
    .sel       (msel),
    .ext       (ext)
  );

  bcc_periph_decode #(.NUM_PERIPH(NUM_PERIPH)) u_per (
    .clk      (clk),
    .rst_n    (rst_n),
    .page     (addr[15:8]),
    .suppress (boot_block),
    .lo_flat  (lo_flat),
    .hi_flat  (hi_flat),
    .cs_n     (periph_cs_n)
  );

  assign ee_cs_n     = !msel.ee;
  assign flash1_cs_n = !msel.f1;
  assign flash2_cs_n = !msel.f2;
  assign sram_cs_n   = !msel.sram;
  assign win_a14     = ext[0];
  assign win_a15     = ext[1];
  assign ext_a16     = ext[2];
  assign ext_a17     = ext[3];

  // R8: bootstrap-owned ranges see no external select at the pins
  assert_boot_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_block |-> (ee_cs_n && flash1_cs_n && flash2_cs_n && sram_cs_n && (&periph_cs_n)));

  // R2: read data is zero unless a register read is in progress
  assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_sel && rd_wr) |-> (rdata == '0));

  // R3: window bank lines reach the pins
  assert_window_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[15:14] == 2'b01) |-> ({ext_a17, ext_a16, win_a15, win_a14} == bank));
endmodule

// File: tb/bank_cs_ctrl_tb.sv
`timescale 1ns/1ps
module bank_cs_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        rd_wr = 1'b1;
  logic        io_cs_n = 1'b1;
  logic        prog_cs_n = 1'b1;
  logic        gen_cs_n = 1'b1;
  logic        boot_mode = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        ee_cs_n, flash1_cs_n, flash2_cs_n, sram_cs_n;
  logic        win_a14, win_a15, ext_a16, ext_a17;
  logic [2:0]  periph_cs_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench-side copy of programmed state
  logic [3:0] m_bank = 4'h0;
  logic       m_swap = 1'b0;
  logic [7:0] m_lo [3];
  logic [7:0] m_hi [3];

  always #5 clk = ~clk;

  bank_cs_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_wr(rd_wr), .io_cs_n(io_cs_n),
    .prog_cs_n(prog_cs_n), .gen_cs_n(gen_cs_n), .boot_mode(boot_mode),
    .wdata(wdata), .rdata(rdata), .ee_cs_n(ee_cs_n), .flash1_cs_n(flash1_cs_n),
    .flash2_cs_n(flash2_cs_n), .sram_cs_n(sram_cs_n), .win_a14(win_a14),
    .win_a15(win_a15), .ext_a16(ext_a16), .ext_a17(ext_a17), .periph_cs_n(periph_cs_n)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; rd_wr = 1'b0; wdata = d; io_cs_n = 1'b0;
    @(negedge clk);
    io_cs_n = 1'b1; rd_wr = 1'b1;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_wr = 1'b1; io_cs_n = 1'b0;
    #2 d = rdata;
    io_cs_n = 1'b1;
  endtask

  // expected {ee,f1,f2,sram, a17,a16,a15,a14, periph[2:0]} as active-high bits
  function automatic logic [10:0] model(input logic [15:0] a, input logic pn, input logic gn,
                                        input logic bt);
    logic [3:0] mem;
    logic [3:0] ext;
    logic [2:0] per;
    logic       quiet;
    quiet = bt && (a < 16'h0400 || (a >= 16'hB600 && a < 16'hC000) || a >= 16'hFE00);
    mem = 4'b0000;
    per = 3'b000;
    if (a >= 16'h4000 && a < 16'h8000) ext = m_bank;
    else ext = {3'b000, a[14]};
    if (!quiet) begin
      if (!pn && a >= 16'h4000 && a < 16'h8000)
        mem = m_swap ? 4'b1000 : (m_bank[3] ? 4'b0010 : 4'b0100);
      else if (!pn && a >= 16'h8000)
        mem = 4'b0100;
      if (!gn && a < 16'h4000) mem = 4'b0001;
      for (int k = 0; k < 3; k++)
        if (m_lo[k] != 0 && a[15:8] >= m_lo[k] && a[15:8] <= m_hi[k]) per[k] = 1'b1;
    end
    return {mem, ext, per};
  endfunction

  function automatic logic [10:0] pins();
    return {~ee_cs_n, ~flash1_cs_n, ~flash2_cs_n, ~sram_cs_n,
            ext_a17, ext_a16, win_a15, win_a14, ~periph_cs_n};
  endfunction

  task automatic probe(input string req, input logic [15:0] a, input logic pn, input logic gn);
    addr = a; prog_cs_n = pn; gen_cs_n = gn;
    #1;
    check(req, 32'(pins()), 32'(model(a, pn, gn, boot_mode)));
  endtask

  task automatic set_bank(input logic [3:0] b);
    wr(16'h1400, {4'h0, b}); m_bank = b;
  endtask
  task automatic set_swap(input logic s);
    wr(16'h1401, {7'h0, s}); m_swap = s;
  endtask
  task automatic set_range(input int k, input logic [7:0] lo, input logic [7:0] hi);
    wr(16'h1400 + 16'(2 + 2*k), lo); wr(16'h1400 + 16'(3 + 2*k), hi);
    m_lo[k] = lo; m_hi[k] = hi;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int i = 0; i < 16; i++) begin
      rd(16'h1400 + 16'(i), d);
      check("R1 reset register", 32'(d), 0);
    end
    @(negedge clk);
    probe("R1 no periph select at reset", 16'h2000, 1'b1, 1'b1);
    check("R1 periph idle", 32'(periph_cs_n), 32'h7);
    probe("R1 swap off at reset", 16'h5000, 1'b0, 1'b1);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(16'h140C, 8'hA5);
    rd(16'h140C, d); check("R2 readback", 32'(d), 32'hA5);
    rd(16'h144C, d); check("R2 mirror read", 32'(d), 32'hA5);
    wr(16'h14CD, 8'h3C);
    rd(16'h140D, d); check("R2 mirror write", 32'(d), 32'h3C);
    wr(16'h141C, 8'hFF);
    rd(16'h140C, d); check("R2 A4 set ignored", 32'(d), 32'hA5);
    wr(16'h150C, 8'h11);
    rd(16'h140C, d); check("R2 A8 set ignored", 32'(d), 32'hA5);
    // write lands on the first edge: check right after it
    @(negedge clk);
    addr = 16'h140E; rd_wr = 1'b0; wdata = 8'h77; io_cs_n = 1'b0;
    @(posedge clk); #1;
    rd_wr = 1'b1; #1;
    check("R2 write next edge", 32'(rdata), 32'h77);
    io_cs_n = 1'b1; #1;
    check("R2 rdata idle zero", 32'(rdata), 0);
  endtask

  task automatic t_window();
    set_bank(4'h5);
    @(negedge clk);
    probe("R3 bank 5 device 1", 16'h4123, 1'b0, 1'b1);
    check("R3 flash1 low", 32'(flash1_cs_n), 0);
    set_bank(4'hB);
    @(negedge clk);
    probe("R3 bank B device 2", 16'h7FFF, 1'b0, 1'b1);
    check("R3 ext lines", 32'({ext_a17, ext_a16, win_a15, win_a14}), 32'hB);
    probe("R6 window without strobe", 16'h6000, 1'b1, 1'b0);
  endtask

  task automatic t_common();
    probe("R4 common low half", 16'h8000, 1'b0, 1'b1);
    probe("R4 common high half", 16'hC321, 1'b0, 1'b1);
    check("R4 a14 follows", 32'(win_a14), 1);
    probe("R6 sram region", 16'h1234, 1'b1, 1'b0);
    probe("R6 no sram above window base", 16'h9000, 1'b1, 1'b0);
  endtask

  task automatic t_swap();
    set_swap(1'b1);
    @(negedge clk);
    probe("R5 swap window", 16'h4800, 1'b0, 1'b1);
    check("R5 ee low", 32'(ee_cs_n), 0);
    probe("R5 swap leaves common", 16'hA000, 1'b0, 1'b1);
    set_swap(1'b0);
  endtask

  task automatic t_periph();
    set_range(0, 8'h20, 8'h21);
    set_range(1, 8'h30, 8'h30);
    set_range(2, 8'h50, 8'h40);
    @(negedge clk);
    probe("R7 inside range 0", 16'h2180, 1'b1, 1'b1);
    probe("R7 above range 0", 16'h2200, 1'b1, 1'b1);
    probe("R7 below range 0", 16'h1FFF, 1'b1, 1'b1);
    probe("R7 single page", 16'h30FF, 1'b1, 1'b1);
    probe("R7 inverted range empty", 16'h4500, 1'b1, 1'b1);
    check("R7 periph2 high", 32'(periph_cs_n[2]), 1);
  endtask

  task automatic t_boot();
    set_range(0, 8'hFD, 8'hFF);
    @(negedge clk);
    boot_mode = 1'b1;
    probe("R8 internal eeprom range", 16'hFE10, 1'b0, 1'b0);
    check("R8 all high", 32'({ee_cs_n, flash1_cs_n, flash2_cs_n, sram_cs_n, periph_cs_n}), 32'h7F);
    probe("R8 just below eeprom", 16'hFDFF, 1'b0, 1'b0);
    probe("R8 boot rom range", 16'hB600, 1'b0, 1'b0);
    probe("R8 below boot rom", 16'hB5FF, 1'b0, 1'b0);
    probe("R8 internal sram", 16'h03FF, 1'b0, 1'b0);
    probe("R8 above internal sram", 16'h0400, 1'b0, 1'b0);
    boot_mode = 1'b0;
    probe("R8 normal after boot", 16'hFE10, 1'b0, 1'b0);
  endtask

  task automatic sweep(input string tag);
    int bad = 0;
    int multi = 0;
    logic [10:0] p;
    for (int a = 0; a < 65536; a++) begin
      addr = 16'(a); prog_cs_n = 1'b0; gen_cs_n = 1'b0;
      #1;
      p = pins();
      if ($countones(p[10:7]) > 1) multi++;
      if (p !== model(16'(a), 1'b0, 1'b0, boot_mode)) bad++;
    end
    check({"R9 exclusive ", tag}, 32'(multi), 0);
    check({"R9 sweep model ", tag}, 32'(bad), 0);
  endtask

  task automatic t_sweeps();
    set_bank(4'h9); set_swap(1'b0);
    @(negedge clk); sweep("bank9");
    set_swap(1'b1);
    @(negedge clk); sweep("swap");
    boot_mode = 1'b1;
    sweep("boot");
    boot_mode = 1'b0;
    set_bank(4'h2); set_swap(1'b0);
    @(negedge clk); sweep("bank2");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin m_lo[k] = 8'h00; m_hi[k] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_window();
    t_common();
    t_swap();
    t_periph();
    t_boot();
    t_sweeps();
    finish_run();
  end

  initial begin
    #1_500_000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule